// File: doc/BRIEF.md
# Hybrid Staircase and Auxiliary PWM Modulator

This block turns a signed sinusoidal reference, one sample per clock, into the control words for a hybrid multilevel inverter. The magnitude of each sample is cut into whole steps of a programmable size, which set the coarse level of the series/parallel source stage. The part of the sample left over after those whole steps is the residual. It is compared against a triangular carrier to produce the PWM bit for the small auxiliary source that adds a fraction of a step. A sign bit picks the polarity of the output bridge. A zero-level request asks the bridge to short the load for a true zero output.

The reference is split into bands. In band ZERO the magnitude is below one step and the zero level is enabled, so a zero request is raised. In band FLOOR the magnitude is below one step but the zero level is disabled, so the output rests on one full step, because the level stage cannot make zero. In band STEP the magnitude covers one or two whole steps. In band SAT all three steps are active and the residual is clamped. The carrier is a two-state machine: in state RISE it counts up, and at the programmed peak it takes the transition to FALL. In FALL it counts down, and on reaching zero it takes the transition back to RISE. The count period is set by `car_half`. A 100 MHz clock with `car_half` = 6667 gives a carrier of about 7.5 kHz. The auxiliary stage adds either a full step or a half step, selected by `half_mode`.

Top module: `hybrid_stair_mod`

## Requirements
- R1: While `rst_n` is low, `sign_out`, `step_idx`, `aux_pwm` and `zero_req` are all 0.
- R2: Two clock edges after a sample is captured, `sign_out` is 1 exactly when that sample was negative (two's complement, so zero counts as positive).
- R3: Let m be the magnitude of the sample and s be `step_size`. When m is at least s, `step_idx` equals the number of values k in {1,2,3} with m >= k*s. It saturates at 3, and the latency is the same as for R2.
- R4: When m < s and `zero_en` is 1, the outputs give `zero_req`=1, `step_idx`=0 and `aux_pwm`=0.
- R5: When m < s and `zero_en` is 0, the outputs give `zero_req`=0, `step_idx`=1 and `aux_pwm`=0.
- R6: The carrier starts at 0 on reset. On each clock it moves by exactly one, up from 0 to `car_half` and back down to 0, so its period is 2*`car_half` clocks. It never exceeds `car_half`.
- R7: Let n be the number of active steps and r = min(m - n*s, range). The value of `aux_pwm` is 1 exactly when r*`car_half` > c*range, where c is the carrier value on the edge that registers the bit.
- R8: The range is s when `half_mode` is 0 and floor(s/2) when `half_mode` is 1. A residual above the range is clamped to the range.
- R9: When m >= 4*s, the residual is clamped to the full range. `aux_pwm` is then 1 on every carrier position except the peak.
- R10: `zero_req` is never 1 while `step_idx` is nonzero or while `aux_pwm` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_sample | input | REF_W (16) | Signed reference sample, two's complement |
| step_size | input | REF_W (16) | Size of one staircase step in reference units |
| car_half | input | CAR_W (16) | Carrier half period in clocks, at least 1 |
| half_mode | input | 1 | 1: auxiliary adds a half step; 0: a full step |
| zero_en | input | 1 | 1: allow a true zero level below one step |
| sign_out | output | 1 | Polarity: 1 for the negative half cycle |
| step_idx | output | 2 | Number of level-stage steps in series (0 to 3) |
| aux_pwm | output | 1 | Gate bit for the auxiliary source |
| zero_req | output | 1 | Request for the bridge zero state |

## Verification
The assertions assume that `car_half` is at least 1 and does not change while the block is out of reset. The carrier bound and the one-count slope both depend on this. The bench keeps to that assumption: it changes `car_half` only while reset is held. It uses three values, 5, 17 and the nominal 6667. The sample, step size, mode and zero enable change freely from cycle to cycle. Their random values cluster around whole multiples of the step and around the extremes of the sample range. This makes the band edges and the saturation clamp come up often.

// File: rtl/hsm_pkg.sv
package hsm_pkg;

    typedef enum logic {
        CAR_RISE,
        CAR_FALL
    } car_dir_e;

    typedef enum logic [1:0] {
        BAND_ZERO,
        BAND_FLOOR,
        BAND_STEP,
        BAND_SAT
    } band_e;

endpackage

// File: rtl/hsm_carrier.sv
module hsm_carrier
    import hsm_pkg::*;
#(
    parameter int CAR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CAR_W-1:0] car_half,
    output logic [CAR_W-1:0] car_val
);

    car_dir_e         dir_q, dir_d;
    logic [CAR_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= CAR_RISE;
            cnt_q <= '0;
        end else begin
            dir_q <= dir_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        dir_d = dir_q;
        cnt_d = cnt_q;
        unique case (dir_q)
            CAR_RISE: begin
                if (cnt_q >= car_half) begin
                    dir_d = CAR_FALL;
                    cnt_d = cnt_q - 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            CAR_FALL: begin
                if (cnt_q == '0) begin
                    dir_d = CAR_RISE;
                    cnt_d = CAR_W'(1);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: begin
                dir_d = CAR_RISE;
                cnt_d = '0;
            end
        endcase
    end

    assign car_val = cnt_q;

endmodule

// File: rtl/hsm_slicer.sv
module hsm_slicer
    import hsm_pkg::*;
#(
    parameter int REF_W = 16,
    parameter int STEPS = 3,
    localparam int IDX_W = $clog2(STEPS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [REF_W-1:0] ref_sample,
    input  logic [REF_W-1:0]        step_size,
    input  logic                    half_mode,
    input  logic                    zero_en,
    output logic                    s1_sign,
    output logic [IDX_W-1:0]        s1_idx,
    output logic                    s1_zero,
    output logic [REF_W-1:0]        s1_resid,
    output logic [REF_W-1:0]        s1_range
);

    localparam int ACC_W = REF_W + IDX_W + 1;

    logic [REF_W-1:0] mag;
    logic [STEPS-1:0] ge;
    logic [IDX_W-1:0] cnt_raw;
    logic [ACC_W-1:0] base;
    logic [ACC_W-1:0] resid_raw;
    logic [REF_W-1:0] range_d;
    band_e            band;

    logic [IDX_W-1:0] idx_d;
    logic             zero_d;
    logic [REF_W-1:0] resid_d;

    assign mag = ref_sample[REF_W-1] ? REF_W'(-ref_sample) : REF_W'(ref_sample);

    for (genvar i = 0; i < STEPS; i++) begin : g_thr
        logic [ACC_W-1:0] thr;
        assign thr   = ACC_W'(step_size) * ACC_W'(i + 1);
        assign ge[i] = ACC_W'(mag) >= thr;
    end

    assign cnt_raw   = IDX_W'($countones(ge));
    assign base      = ACC_W'(cnt_raw) * ACC_W'(step_size);
    assign resid_raw = ACC_W'(mag) - base;
    assign range_d   = half_mode ? (step_size >> 1) : step_size;

    always_comb begin
        if (cnt_raw == '0)
            band = zero_en ? BAND_ZERO : BAND_FLOOR;
        else if (cnt_raw == IDX_W'(STEPS))
            band = BAND_SAT;
        else
            band = BAND_STEP;
    end

    always_comb begin
        idx_d   = '0;
        zero_d  = 1'b0;
        resid_d = '0;
        unique case (band)
            BAND_ZERO: begin
                zero_d = 1'b1;
            end
            BAND_FLOOR: begin
                idx_d = IDX_W'(1);
            end
            BAND_STEP, BAND_SAT: begin
                idx_d = cnt_raw;
                if (resid_raw > ACC_W'(range_d))
                    resid_d = range_d;
                else
                    resid_d = REF_W'(resid_raw);
            end
            default: begin
                idx_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_sign  <= 1'b0;
            s1_idx   <= '0;
            s1_zero  <= 1'b0;
            s1_resid <= '0;
            s1_range <= '0;
        end else begin
            s1_sign  <= ref_sample[REF_W-1];
            s1_idx   <= idx_d;
            s1_zero  <= zero_d;
            s1_resid <= resid_d;
            s1_range <= range_d;
        end
    end

endmodule

// File: rtl/hsm_aux_cmp.sv
module hsm_aux_cmp #(
    parameter int REF_W = 16,
    parameter int CAR_W = 16,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s1_sign,
    input  logic [IDX_W-1:0] s1_idx,
    input  logic             s1_zero,
    input  logic [REF_W-1:0] s1_resid,
    input  logic [REF_W-1:0] s1_range,
    input  logic [CAR_W-1:0] car_val,
    input  logic [CAR_W-1:0] car_half,
    output logic             sign_out,
    output logic [IDX_W-1:0] step_idx,
    output logic             aux_pwm,
    output logic             zero_req
);

    localparam int PROD_W = REF_W + CAR_W;

    logic [PROD_W-1:0] lhs;
    logic [PROD_W-1:0] rhs;
    logic              aux_d;

    assign lhs   = PROD_W'(s1_resid) * PROD_W'(car_half);
    assign rhs   = PROD_W'(car_val) * PROD_W'(s1_range);
    assign aux_d = (lhs > rhs) && !s1_zero;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sign_out <= 1'b0;
            step_idx <= '0;
            aux_pwm  <= 1'b0;
            zero_req <= 1'b0;
        end else begin
            sign_out <= s1_sign;
            step_idx <= s1_idx;
            aux_pwm  <= aux_d;
            zero_req <= s1_zero;
        end
    end

endmodule

// File: rtl/hybrid_stair_mod.sv
module hybrid_stair_mod #(
    parameter int REF_W = 16,
    parameter int CAR_W = 16,
    parameter int STEPS = 3,
    localparam int IDX_W = $clog2(STEPS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [REF_W-1:0] ref_sample,
    input  logic [REF_W-1:0]        step_size,
    input  logic [CAR_W-1:0]        car_half,
    input  logic                    half_mode,
    input  logic                    zero_en,
    output logic                    sign_out,
    output logic [IDX_W-1:0]        step_idx,
    output logic                    aux_pwm,
    output logic                    zero_req
);

    logic             s1_sign;
    logic [IDX_W-1:0] s1_idx;
    logic             s1_zero;
    logic [REF_W-1:0] s1_resid;
    logic [REF_W-1:0] s1_range;
    logic [CAR_W-1:0] car_val;

    hsm_carrier #(.CAR_W(CAR_W)) u_carrier (
        .clk      (clk),
        .rst_n    (rst_n),
        .car_half (car_half),
        .car_val  (car_val)
    );

    hsm_slicer #(.REF_W(REF_W), .STEPS(STEPS)) u_slicer (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_sample (ref_sample),
        .step_size  (step_size),
        .half_mode  (half_mode),
        .zero_en    (zero_en),
        .s1_sign    (s1_sign),
        .s1_idx     (s1_idx),
        .s1_zero    (s1_zero),
        .s1_resid   (s1_resid),
        .s1_range   (s1_range)
    );

    hsm_aux_cmp #(.REF_W(REF_W), .CAR_W(CAR_W), .IDX_W(IDX_W)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .s1_sign  (s1_sign),
        .s1_idx   (s1_idx),
        .s1_zero  (s1_zero),
        .s1_resid (s1_resid),
        .s1_range (s1_range),
        .car_val  (car_val),
        .car_half (car_half),
        .sign_out (sign_out),
        .step_idx (step_idx),
        .aux_pwm  (aux_pwm),
        .zero_req (zero_req)
    );

endmodule

// File: rtl/hsm_checker.sv
module hsm_checker #(
    parameter int REF_W = 16,
    parameter int CAR_W = 16,
    parameter int IDX_W = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic signed [REF_W-1:0] ref_sample,
    input logic [CAR_W-1:0]        car_half,
    input logic [CAR_W-1:0]        car_val,
    input logic                    sign_out,
    input logic [IDX_W-1:0]        step_idx,
    input logic                    aux_pwm,
    input logic                    zero_req
);

    logic [1:0] seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            seen <= '0;
        else if (seen != 2'd3)
            seen <= seen + 2'd1;
    end

    // R10: a zero request never coexists with a step or an auxiliary pulse
    a_r10_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        zero_req |-> (step_idx == '0 && !aux_pwm));

    // R5: without a zero request the level stage always carries a step
    a_r5_floor_step: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 2'd2 && !zero_req) |-> (step_idx != '0));

    // R2: polarity follows the sample sign two edges later
    a_r2_sign_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 2'd2) |-> (sign_out == $past(ref_sample[REF_W-1], 2)));

    // R6: carrier stays within its programmed peak
    a_r6_car_bound: assert property (@(posedge clk) disable iff (!rst_n)
        car_val <= car_half);

    // R6: carrier moves by exactly one count per clock
    a_r6_car_slope: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 2'd1) |->
        ((CAR_W+1)'(car_val) == (CAR_W+1)'($past(car_val)) + 1'b1 ||
         (CAR_W+1)'(car_val) + 1'b1 == (CAR_W+1)'($past(car_val))));

endmodule

bind hybrid_stair_mod hsm_checker #(.REF_W(REF_W), .CAR_W(CAR_W), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_sample (ref_sample),
    .car_half   (car_half),
    .car_val    (car_val),
    .sign_out   (sign_out),
    .step_idx   (step_idx),
    .aux_pwm    (aux_pwm),
    .zero_req   (zero_req)
);

// File: tb/tb_hybrid_stair_mod.sv
`timescale 1ns/1ps
module tb_hybrid_stair_mod;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic signed [15:0] ref_sample = '0;
    logic [15:0]        step_size = 16'd1000;
    logic [15:0]        car_half = 16'd5;
    logic               half_mode = 1'b0;
    logic               zero_en = 1'b1;
    logic               sign_out;
    logic [1:0]         step_idx;
    logic               aux_pwm;
    logic               zero_req;

    int n_chk = 0;
    int n_bad = 0;
    int e = 0;
    int h_ref[4];
    int h_step[4];
    int h_half[4];
    int h_zen[4];
    bit done = 0;

    always #5 clk = ~clk;

    hybrid_stair_mod dut (
        .clk(clk), .rst_n(rst_n), .ref_sample(ref_sample), .step_size(step_size),
        .car_half(car_half), .half_mode(half_mode), .zero_en(zero_en),
        .sign_out(sign_out), .step_idx(step_idx), .aux_pwm(aux_pwm), .zero_req(zero_req)
    );

    task automatic report();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d (edge %0d)", tag, got, exp, e);
        end
    endtask

    function automatic int tri_at(input int k, input int p);
        int t;
        t = k % (2 * p);
        return (t <= p) ? t : 2 * p - t;
    endfunction

    function automatic int mag_of(input int r);
        return (r < 0) ? -r : r;
    endfunction

    function automatic int nsteps(input int m, input int s);
        int c = 0;
        for (int k = 1; k <= 3; k++) if (m >= k * s) c++;
        return c;
    endfunction

    task automatic check_slot(input int slot, input int car);
        int m, s, c, rng, rc, x_idx, x_zero, x_aux;
        m = mag_of(h_ref[slot]);
        s = h_step[slot];
        c = nsteps(m, s);
        rng = h_half[slot] ? s / 2 : s;
        if (c == 0) begin
            rc = 0;
            x_zero = h_zen[slot];
            x_idx = h_zen[slot] ? 0 : 1;
        end else begin
            x_zero = 0;
            x_idx = c;
            rc = m - c * s;
            if (rc > rng) rc = rng;
        end
        x_aux = ((longint'(rc) * car_half) > (longint'(car) * rng)) ? 1 : 0;
        chk("R2 sign", sign_out, (h_ref[slot] < 0) ? 1 : 0);
        chk(c == 0 ? (h_zen[slot] ? "R4 idx" : "R5 idx") : "R3 idx", step_idx, x_idx);
        chk(c == 0 ? "R4/R5 zero" : "R10 zero", zero_req, x_zero);
        if (c == 0)
            chk(h_zen[slot] ? "R4 aux" : "R5 aux", aux_pwm, 0);
        else if (m >= 4 * s)
            chk("R9 aux", aux_pwm, x_aux);
        else
            chk(h_half[slot] ? "R8 aux" : "R7 aux", aux_pwm, x_aux);
    endtask

    task automatic cycle(input int r, input int s, input int hm, input int ze);
        int slot;
        ref_sample = 16'(r);
        step_size  = 16'(s);
        half_mode  = hm[0];
        zero_en    = ze[0];
        slot = (e + 1) % 4;
        h_ref[slot] = r; h_step[slot] = s; h_half[slot] = hm; h_zen[slot] = ze;
        @(posedge clk);
        e++;
        @(negedge clk);
        if (e >= 2) check_slot((e - 1) % 4, tri_at(e - 1, car_half));
    endtask

    task automatic do_reset(input int p);
        @(negedge clk);
        rst_n = 1'b0;
        car_half = 16'(p);
        @(negedge clk);
        chk("R1 sign", sign_out, 0);
        chk("R1 idx", step_idx, 0);
        chk("R1 aux", aux_pwm, 0);
        chk("R1 zero", zero_req, 0);
        rst_n = 1'b1;
        e = 0;
    endtask

    task automatic random_run(input int n);
        int s = 1000, hm = 0, ze = 1, r, md;
        for (int i = 0; i < n; i++) begin
            if (i % 64 == 0) begin
                s  = 300 + int'($urandom % 7700);
                hm = int'($urandom % 2);
                ze = int'($urandom % 2);
            end
            md = int'($urandom % 4);
            case (md)
                0: r = int'($urandom % 65536) - 32768;
                1: r = int'($urandom % 5) * s + int'($urandom % 7) - 3;
                2: r = int'($urandom % 8) - 4;
                default: r = ($urandom % 2) ? 32767 : -32768;
            endcase
            if (md == 1 && ($urandom % 2)) r = -r;
            if (r > 32767) r = 32767;
            if (r < -32768) r = -32768;
            cycle(r, s, hm, ze);
        end
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (2) @(negedge clk);
        do_reset(5);
        // directed band edges, full step, zero level on (R3 R4 R7 R9)
        cycle(0, 1000, 0, 1);
        cycle(999, 1000, 0, 1);
        cycle(1000, 1000, 0, 1);
        cycle(-1000, 1000, 0, 1);
        cycle(1999, 1000, 0, 1);
        cycle(2500, 1000, 0, 1);
        cycle(3999, 1000, 0, 1);
        cycle(4000, 1000, 0, 1);
        cycle(32767, 1000, 0, 1);
        cycle(-32768, 1000, 0, 1);
        cycle(-1, 1000, 0, 1);
        // zero level off: floor at one step (R5)
        cycle(0, 1000, 0, 0);
        cycle(-500, 1000, 0, 0);
        // half-step range clamp (R8)
        cycle(1700, 1000, 1, 0);
        cycle(1300, 1000, 1, 1);
        cycle(3600, 1000, 1, 1);
        for (int i = 0; i < 12; i++) cycle(5000, 1000, 0, 1);
        random_run(3000);
        do_reset(17);
        random_run(3000);
        do_reset(6667);
        random_run(30000);
        cycle(0, 1000, 0, 1);
        cycle(0, 1000, 0, 1);
        report();
    end

endmodule